// File: doc/BRIEF.md
# Palette DAC Strobe Decoder

This block sits between a host I/O bus and an external palette DAC. It watches host I/O cycles, decides whether each one targets the palette port window, and drives active-low read and write strobes to the DAC. The host can run either of two bus styles, chosen by a strap input. In the PC style, separate I/O read and I/O write strobes are qualified by an address-enable line. In the command/status style, a command strobe is qualified by a two-bit status code and a memory/IO line. In that style, the address and status are captured when the command strobe first goes low.

The palette window covers I/O ports 03C6h to 03C9h. An alias-enable bit can add a second window at 83C6h to 83C9h. Port 03C7h is the palette state port, and reads of it are answered inside the chip. For such a read the block raises an internal select and does not pulse the DAC. Writes to 03C7h still go to the DAC. A chip-enable input and an active-low refresh input stop every decode while they are inactive. The outputs are registered. A strobe follows the host command on the first clock edge that sees the command active, and it drops on the first edge that sees the command gone.

Top module: `dac_strobe_decode`

## Requirements
- R1: While reset is low, and on every clock before the first qualified cycle, `dac_rd_n` and `dac_wr_n` are 1 and `state_sel` is 0.
- R2: In PC mode (`bus_pc`=1), a read with `io_rd_n`=0, `io_wr_n`=1 and `aen`=0 to address 03C6h, 03C8h or 03C9h drives `dac_rd_n` low from the first clock edge that samples the cycle.
- R3: A qualified read of the state port 03C7h leaves `dac_rd_n` high and drives `state_sel` to 1 instead.
- R4: A qualified write to any address from 03C6h to 03C9h, including 03C7h, drives `dac_wr_n` low.
- R5: Addresses outside the window produce no strobe and no select. This covers 03C5h, 03CAh, 43C6h, and 83C6h to 83C9h while `alias_en`=0.
- R6: With `alias_en`=1, addresses 83C6h to 83C9h decode exactly as 03C6h to 03C9h do.
- R7: In command/status mode (`bus_pc`=0), the cycle is defined by `addr`, `mc_status` (bit 1 = S1, bit 0 = S0) and `mc_mem`, sampled on the first edge that sees `cmd_n` low. Status 01 is a read and 10 is a write. Status 00 and 11, or `mc_mem`=1 (memory cycle), produce nothing. Changes to these inputs while `cmd_n` stays low have no effect.
- R8: In PC mode, `aen`=1 marks the address invalid and the cycle produces nothing.
- R9: While `chip_en`=0 or `refresh_n`=0, no strobe or select asserts on the following edge.
- R10: Strobes and select return inactive on the first edge that samples the command inactive. In PC mode that means both `io_rd_n` and `io_wr_n` high. In command/status mode it means `cmd_n` high.
- R11: In PC mode, `io_rd_n` and `io_wr_n` both low is no cycle, and `cmd_n` is ignored. In command/status mode, `io_rd_n` and `io_wr_n` are ignored.
- R12: `dac_rd_n` and `dac_wr_n` are never low together, and `state_sel` never asserts together with `dac_rd_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_pc | input | 1 | Bus-style strap: 1 = PC style, 0 = command/status style |
| addr | input | ADDR_W | Host I/O address |
| io_rd_n | input | 1 | PC-style I/O read strobe, active low |
| io_wr_n | input | 1 | PC-style I/O write strobe, active low |
| aen | input | 1 | PC-style address enable, 1 = address invalid |
| cmd_n | input | 1 | Command strobe, active low, command/status style |
| mc_status | input | 2 | Status pair {S1,S0}: 01 read, 10 write |
| mc_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| refresh_n | input | 1 | Active-low refresh or disable; low suppresses decoding |
| chip_en | input | 1 | Chip enable; low suppresses decoding |
| alias_en | input | 1 | Enables the 83C6h to 83C9h alias window |
| dac_rd_n | output | 1 | DAC read strobe, active low |
| dac_wr_n | output | 1 | DAC write strobe, active low |
| state_sel | output | 1 | Internal select for a read of the state port |

## Verification
A bad captured address or status in command/status mode shows up on the very edge that samples `cmd_n` low, as a wrong strobe or a missing one. It stays wrong until `cmd_n` rises, so changing the inputs in the middle of a command exposes a capture that keeps tracking them. A wrong window, alias or state-port compare shows one clock after the cycle starts. A strobe that does not release shows on the edge after the command ends. A behavioural model in the bench predicts all three outputs for every clock, so any such slip is reported in the cycle it happens.

// File: rtl/dac_strobe_decode.sv
module dac_strobe_decode #(
  parameter int ADDR_W = 16,
  parameter int LO_W = 12,
  parameter logic [LO_W-1:0] WIN_FIRST = 12'h3C6,
  parameter logic [LO_W-1:0] WIN_LAST = 12'h3C9,
  parameter logic [LO_W-1:0] STATE_PORT = 12'h3C7,
  parameter logic [ADDR_W-LO_W-1:0] ALIAS_PAGE = 4'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_pc,
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_rd_n,
  input  logic              io_wr_n,
  input  logic              aen,
  input  logic              cmd_n,
  input  logic [1:0]        mc_status,
  input  logic              mc_mem,
  input  logic              refresh_n,
  input  logic              chip_en,
  input  logic              alias_en,
  output logic              dac_rd_n,
  output logic              dac_wr_n,
  output logic              state_sel
);
  localparam int HI_W = ADDR_W - LO_W;
  localparam logic [1:0] ST_RD = 2'b01;
  localparam logic [1:0] ST_WR = 2'b10;

  logic              cmd_q;
  logic [ADDR_W-1:0] lat_addr;
  logic [1:0]        lat_st;
  logic              lat_mem;

  wire mc_lead = !cmd_n && cmd_q;
  wire [ADDR_W-1:0] mc_addr = mc_lead ? addr : lat_addr;
  wire [1:0]        mc_st   = mc_lead ? mc_status : lat_st;
  wire              mc_m    = mc_lead ? mc_mem : lat_mem;

  wire pc_rd = bus_pc && !aen && !io_rd_n && io_wr_n;
  wire pc_wr = bus_pc && !aen && io_rd_n && !io_wr_n;
  wire mc_rd = !bus_pc && !cmd_n && !mc_m && (mc_st == ST_RD);
  wire mc_wr = !bus_pc && !cmd_n && !mc_m && (mc_st == ST_WR);

  wire [ADDR_W-1:0] cyc_addr = bus_pc ? addr : mc_addr;
  wire [HI_W-1:0]   hi = cyc_addr[ADDR_W-1:LO_W];
  wire [LO_W-1:0]   lo = cyc_addr[LO_W-1:0];

  wire page_ok  = (hi == '0) || (alias_en && hi == ALIAS_PAGE);
  wire in_win   = page_ok && (lo >= WIN_FIRST) && (lo <= WIN_LAST);
  wire allowed  = chip_en && refresh_n && in_win;
  wire is_state = (lo == STATE_PORT);

  wire rd_hit = allowed && (pc_rd || mc_rd);
  wire wr_hit = allowed && (pc_wr || mc_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= 1'b1;
      lat_addr <= '0;
      lat_st   <= 2'b11;
      lat_mem  <= 1'b1;
    end else begin
      cmd_q <= cmd_n;
      if (mc_lead) begin
        lat_addr <= addr;
        lat_st   <= mc_status;
        lat_mem  <= mc_mem;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_rd_n  <= 1'b1;
      dac_wr_n  <= 1'b1;
      state_sel <= 1'b0;
    end else begin
      dac_rd_n  <= !(rd_hit && !is_state);
      dac_wr_n  <= !wr_hit;
      state_sel <= rd_hit && is_state;
    end
  end

  // R12
  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dac_rd_n && !dac_wr_n));
  a_r12_sel_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(state_sel && !dac_rd_n));
  // R9
  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en || !refresh_n) |=> (dac_rd_n && dac_wr_n && !state_sel));
  // R10
  a_r10_pc_release: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_pc && io_rd_n && io_wr_n) |=> (dac_rd_n && dac_wr_n && !state_sel));
  a_r10_mc_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_pc && cmd_n) |=> (dac_rd_n && dac_wr_n && !state_sel));
  // R8
  a_r8_aen: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_pc && aen) |=> (dac_rd_n && dac_wr_n && !state_sel));
  // R5
  a_r5_no_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_pc && !alias_en && addr[ADDR_W-1:LO_W] != '0) |=> (dac_rd_n && dac_wr_n && !state_sel));
endmodule

// File: tb/tb_dac_strobe_decode.sv
module tb_dac_strobe_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_pc = 1'b1;
  logic [15:0] addr = '0;
  logic io_rd_n = 1'b1, io_wr_n = 1'b1, aen = 1'b0, cmd_n = 1'b1;
  logic [1:0] mc_status = 2'b11;
  logic mc_mem = 1'b1, refresh_n = 1'b1, chip_en = 1'b1, alias_en = 1'b0;
  logic dac_rd_n, dac_wr_n, state_sel;

  int checks = 0, errors = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  dac_strobe_decode dut (
    .clk(clk), .rst_n(rst_n), .bus_pc(bus_pc), .addr(addr),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .aen(aen), .cmd_n(cmd_n),
    .mc_status(mc_status), .mc_mem(mc_mem), .refresh_n(refresh_n),
    .chip_en(chip_en), .alias_en(alias_en),
    .dac_rd_n(dac_rd_n), .dac_wr_n(dac_wr_n), .state_sel(state_sel)
  );

  // behavioural reference model
  logic e_rd = 1'b1, e_wr = 1'b1, e_sel = 1'b0;
  logic m_prev = 1'b1;
  logic [15:0] m_addr = '0;
  logic [1:0] m_st = 2'b11;
  logic m_mem = 1'b1;
  int kind;
  logic [15:0] a;
  logic hit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_rd = 1'b1; e_wr = 1'b1; e_sel = 1'b0; m_prev = 1'b1;
    end else begin
      kind = 0;
      a = addr;
      if (bus_pc) begin
        if (!aen && !io_rd_n && io_wr_n) kind = 1;
        else if (!aen && io_rd_n && !io_wr_n) kind = 2;
      end else if (!cmd_n) begin
        if (m_prev) begin m_addr = addr; m_st = mc_status; m_mem = mc_mem; end
        a = m_addr;
        if (!m_mem && m_st == 2'b01) kind = 1;
        else if (!m_mem && m_st == 2'b10) kind = 2;
      end
      m_prev = cmd_n;
      if (!refresh_n || !chip_en) kind = 0;
      hit = (a[11:0] >= 12'h3C6) && (a[11:0] <= 12'h3C9) &&
            (a[15:12] == 4'h0 || (alias_en && a[15:12] == 4'h8));
      e_rd  = !(kind == 1 && hit && a[11:0] != 12'h3C7);
      e_wr  = !(kind == 2 && hit);
      e_sel = (kind == 1 && hit && a[11:0] == 12'h3C7);
    end
  end

  task automatic check(string tag, logic ar, logic aw, logic as, logic xr, logic xw, logic xs);
    checks++;
    if (ar !== xr || aw !== xw || as !== xs) begin
      errors++;
      $display("FAIL %s: rd_n/wr_n/sel actual=%b%b%b expected=%b%b%b", tag, ar, aw, as, xr, xw, xs);
    end
  endtask

  always @(negedge clk)
    if (rst_n) check({cur_tag, " model"}, dac_rd_n, dac_wr_n, state_sel, e_rd, e_wr, e_sel);

  task automatic cyc(string tag, bit pc, logic [15:0] ad, bit rd, bit wr, logic [1:0] st,
                     bit mem, bit midchange, bit xr, bit xw, bit xs);
    @(negedge clk);
    cur_tag = tag;
    bus_pc = pc; addr = ad;
    if (pc) begin io_rd_n = !rd; io_wr_n = !wr; end
    else begin mc_status = st; mc_mem = mem; cmd_n = 1'b0; io_rd_n = !rd; io_wr_n = !wr; end
    @(negedge clk);
    if (midchange) begin addr = 16'h0000; mc_status = 2'b10; mc_mem = 1'b1; end
    @(negedge clk);
    check(tag, dac_rd_n, dac_wr_n, state_sel, xr, xw, xs);
    io_rd_n = 1'b1; io_wr_n = 1'b1; cmd_n = 1'b1;
    @(negedge clk);
    check("R10", dac_rd_n, dac_wr_n, state_sel, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", dac_rd_n, dac_wr_n, state_sel, 1'b1, 1'b1, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", dac_rd_n, dac_wr_n, state_sel, 1'b1, 1'b1, 1'b0);
    // PC style
    cyc("R2", 1, 16'h03C6, 1, 0, 2'b11, 1, 0, 0, 1, 0);
    cyc("R2", 1, 16'h03C8, 1, 0, 2'b11, 1, 0, 0, 1, 0);
    cyc("R2", 1, 16'h03C9, 1, 0, 2'b11, 1, 0, 0, 1, 0);
    cyc("R3", 1, 16'h03C7, 1, 0, 2'b11, 1, 0, 1, 1, 1);
    for (int i = 0; i < 4; i++)
      cyc("R4", 1, 16'h03C6 + 16'(i), 0, 1, 2'b11, 1, 0, 1, 0, 0);
    cyc("R5", 1, 16'h03C5, 1, 0, 2'b11, 1, 0, 1, 1, 0);
    cyc("R5", 1, 16'h03CA, 0, 1, 2'b11, 1, 0, 1, 1, 0);
    cyc("R5", 1, 16'h83C6, 0, 1, 2'b11, 1, 0, 1, 1, 0);
    cyc("R5", 1, 16'h83C9, 1, 0, 2'b11, 1, 0, 1, 1, 0);
    alias_en = 1'b1;
    cyc("R6", 1, 16'h83C7, 1, 0, 2'b11, 1, 0, 1, 1, 1);
    cyc("R6", 1, 16'h83C9, 1, 0, 2'b11, 1, 0, 0, 1, 0);
    cyc("R6", 1, 16'h83C8, 0, 1, 2'b11, 1, 0, 1, 0, 0);
    cyc("R5", 1, 16'h43C6, 0, 1, 2'b11, 1, 0, 1, 1, 0);
    alias_en = 1'b0;
    aen = 1'b1;
    cyc("R8", 1, 16'h03C6, 1, 0, 2'b11, 1, 0, 1, 1, 0);
    aen = 1'b0;
    cyc("R11", 1, 16'h03C6, 1, 1, 2'b11, 1, 0, 1, 1, 0);
    chip_en = 1'b0;
    cyc("R9", 1, 16'h03C8, 0, 1, 2'b11, 1, 0, 1, 1, 0);
    chip_en = 1'b1; refresh_n = 1'b0;
    cyc("R9", 1, 16'h03C8, 1, 0, 2'b11, 1, 0, 1, 1, 0);
    refresh_n = 1'b1;
    // PC style ignores the command strobe (R11)
    @(negedge clk);
    cur_tag = "R11"; bus_pc = 1'b1; addr = 16'h03C6; mc_status = 2'b01; mc_mem = 1'b0; cmd_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R11", dac_rd_n, dac_wr_n, state_sel, 1'b1, 1'b1, 1'b0);
    cmd_n = 1'b1;
    @(negedge clk);
    // command/status style
    cyc("R7", 0, 16'h03C6, 0, 0, 2'b01, 0, 0, 0, 1, 0);
    cyc("R3", 0, 16'h03C7, 0, 0, 2'b01, 0, 0, 1, 1, 1);
    cyc("R7", 0, 16'h03C9, 0, 0, 2'b10, 0, 0, 1, 0, 0);
    cyc("R7", 0, 16'h03C8, 0, 0, 2'b00, 0, 0, 1, 1, 0);
    cyc("R7", 0, 16'h03C8, 0, 0, 2'b11, 0, 0, 1, 1, 0);
    cyc("R7", 0, 16'h03C8, 0, 0, 2'b01, 1, 0, 1, 1, 0);
    cyc("R7", 0, 16'h03C8, 0, 0, 2'b01, 0, 1, 0, 1, 0);
    alias_en = 1'b1;
    cyc("R6", 0, 16'h83C6, 0, 0, 2'b10, 0, 0, 1, 0, 0);
    alias_en = 1'b0;
    cyc("R11", 0, 16'h03C6, 1, 0, 2'b11, 0, 0, 1, 1, 0);
    chip_en = 1'b0;
    cyc("R9", 0, 16'h03C6, 0, 0, 2'b01, 0, 0, 1, 1, 0);
    chip_en = 1'b1;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule